// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block feeds a transmit FIFO from host memory by following a chain of transmit descriptors. Every descriptor is three 32-bit words at consecutive word addresses: the link to the next descriptor at +0, the command/status word at +4 and the buffer pointer at +8. Software loads the current descriptor pointer and sets the enable bit. The engine then reads descriptors and pulls their buffer data into the FIFO in pieces that fit the free space. When a descriptor is finished, it either writes its status back or marks the end of the packet in the FIFO. It then follows the link.

When the link is null, the engine stops and remembers that the current descriptor is finished. The next time transmit is enabled, it re-reads only the link word of that finished descriptor, so descriptors appended by software are picked up without sending the old one again. If software has written a new pointer in the meantime, the engine reads the full descriptor at that pointer instead.

All memory traffic goes through one request/done bus-master port with one request outstanding at a time. A read returns its words as data beats, and the done pulse arrives in a cycle after the last beat. A write carries one data word and per-byte-lane enables.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the pointer reads 0, enable is 0, no bus request or FIFO write is active, the idle interrupt is low and the done flag is clear.
- R2: With enable set and the done flag clear, the engine in idle issues a 12-byte read at the pointer (link, command/status, buffer pointer).
- R3: If the command/status word read has bit 31 (ownership) clear, no data moves, a one-cycle idle interrupt is raised and the engine returns to idle with enable still set, so it fetches the same descriptor again until ownership is granted.
- R4: A fragment read starts only when FIFO free space is strictly greater than the threshold. Its length is the smaller of free space and the bytes remaining. The remaining count starts at command/status bits 11:0, and successive reads advance the address from the buffer pointer by the lengths already read.
- R5: Every data beat of a fragment read is written to the FIFO in order, with tag 0 and the beat data.
- R6: When the remaining count is zero and bit 30 (more-follows) is set, the engine issues a write to descriptor address + 4 with byte enables 4'b1100 and bit 31 cleared, leaving the lower half of the word unchanged, and pushes no handle.
- R7: When the remaining count is zero and bit 30 is clear, exactly one FIFO entry with tag 1 and the descriptor address as data is written.
- R8: After a descriptor with a non-null link, the pointer takes the link value and the next request is a 12-byte read at that link.
- R9: After a descriptor with a null link, the engine raises a one-cycle idle interrupt, clears enable and sets the done flag. The next enable issues a 4-byte read at the pointer and then follows the link word returned.
- R10: A software pointer write is visible at the next clock edge, clears the done flag so the next enable reads the full descriptor at the new pointer, and wins over a link load in the same cycle.
- R11: A bus request, once raised, stays high with stable address, length, write flag, data and enables until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txdp_wr_i | input | 1 | Software write strobe for the descriptor pointer |
| txdp_wdata_i | input | AW | Pointer value written by software |
| txe_set_i | input | 1 | Software strobe that sets the transmit enable |
| txdp_o | output | AW | Current descriptor pointer |
| txe_o | output | 1 | Transmit enable state |
| idle_irq_o | output | 1 | One-cycle idle interrupt pulse |
| bus_req_o | output | 1 | Bus request, held until done |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | AW | Byte address of the request |
| bus_len_o | output | 12 | Request length in bytes |
| bus_wdata_o | output | 32 | Write data |
| bus_be_o | output | 4 | Write byte-lane enables |
| bus_rvalid_i | input | 1 | Read data beat valid |
| bus_rdata_i | input | 32 | Read data beat |
| bus_done_i | input | 1 | Request complete, in a cycle after the last beat |
| fifo_free_i | input | FW | Free bytes in the transmit FIFO |
| fifo_thr_i | input | FW | Fill threshold in bytes |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_tag_o | output | 1 | 1 marks a descriptor-address handle |
| fifo_wdata_o | output | 32 | FIFO write data |

## Verification
A pointer write is due at the first rising edge after the strobe. A request appears one edge after the state that issues it. A FIFO entry follows its data beat by one cycle, and the idle interrupt is high for the single cycle after the done pulse or advance step that raises it. The bench drives all inputs and samples all outputs on the falling edge. It does not assume a fixed latency for whole transfers: it waits for enable to drop or for an interrupt count to be reached, with bounded timeouts, and only then compares the logged requests, FIFO entries and memory contents. The hold-and-stability rule for requests is checked on every falling edge by the memory model.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DREFR, ST_DREAD, ST_FBLOCK, ST_FREAD, ST_DWRITE, ST_ADV
  } tx_state_e;

  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned MORE_BIT   = 30;
  localparam int unsigned CNT_W      = 12;
  localparam int unsigned DESC_WORDS = 3;
endpackage

// File: rtl/txdesc_ptr.sv
module txdesc_ptr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_wr_i,
  input  logic [AW-1:0] sw_wdata_i,
  input  logic          txe_set_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          set_done_i,
  input  logic          clr_txe_i,
  output logic [AW-1:0] txdp_o,
  output logic          done_o,
  output logic          txe_o
);
  logic [AW-1:0] txdp_q;
  logic          done_q, txe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txdp_q <= '0;
      done_q <= 1'b0;
      txe_q  <= 1'b0;
    end else begin
      // software write wins over engine load
      if (sw_wr_i)   txdp_q <= sw_wdata_i;
      else if (ld_i) txdp_q <= ld_addr_i;

      if (sw_wr_i || ld_i) done_q <= 1'b0;
      else if (set_done_i) done_q <= 1'b1;

      if (txe_set_i)      txe_q <= 1'b1;
      else if (clr_txe_i) txe_q <= 1'b0;
    end
  end

  assign txdp_o = txdp_q;
  assign done_o = done_q;
  assign txe_o  = txe_q;

  // R10
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr_i |=> (txdp_q == $past(sw_wdata_i)) && !done_q);
endmodule

// File: rtl/txdesc_cache.sv
module txdesc_cache
  import txdesc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        cap_en_i,
  input  logic [31:0] rdata_i,
  output logic [31:0] link_o,
  output logic [31:0] cmdsts_o,
  output logic [31:0] bufptr_o
);
  localparam int unsigned IW = $clog2(DESC_WORDS + 1);

  logic [IW-1:0] idx_q;
  logic [31:0]   word_q [DESC_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             idx_q <= '0;
    else if (start_i)                        idx_q <= '0;
    else if (cap_en_i && idx_q != IW'(DESC_WORDS)) idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q[g] <= '0;
      else if (cap_en_i && idx_q == IW'(g))     word_q[g] <= rdata_i;
    end
  end

  assign link_o   = word_q[0];
  assign cmdsts_o = word_q[1];
  assign bufptr_o = word_q[2];
endmodule

// File: rtl/txdesc_fsm.sv
module txdesc_fsm
  import txdesc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned FW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txe_i,
  input  logic             done_flag_i,
  input  logic [AW-1:0]    txdp_i,
  input  logic [AW-1:0]    link_i,
  input  logic [31:0]      cmdsts_i,
  input  logic [AW-1:0]    bufptr_i,
  input  logic [FW-1:0]    free_i,
  input  logic [FW-1:0]    thr_i,
  input  logic             done_i,
  input  logic             rvalid_i,
  input  logic [31:0]      rdata_i,
  output logic             req_o,
  output logic             we_o,
  output logic [AW-1:0]    addr_o,
  output logic [CNT_W-1:0] len_o,
  output logic [31:0]      wdata_o,
  output logic [3:0]       be_o,
  output logic             start_o,
  output logic             cap_en_o,
  output logic             ld_o,
  output logic             set_done_o,
  output logic             clr_txe_o,
  output logic             irq_o,
  output logic             fifo_we_o,
  output logic             fifo_tag_o,
  output logic [31:0]      fifo_wdata_o
);
  localparam logic [CNT_W-1:0] DESC_LEN = CNT_W'(DESC_WORDS * 4);
  localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(4);

  tx_state_e        st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d, free_ext, xfer_len;
  logic [AW-1:0]    frag_q, frag_d;

  logic             iss, iss_we, push_h, irq_d;
  logic [AW-1:0]    iss_addr;
  logic [CNT_W-1:0] iss_len;
  logic [31:0]      iss_wdata;
  logic [3:0]       iss_be;

  logic             req_q, we_q, irq_q, fwe_q, ftag_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] len_q;
  logic [31:0]      wdata_q, fdata_q;
  logic [3:0]       be_q;

  assign free_ext = CNT_W'(free_i);
  assign xfer_len = (free_ext < rem_q) ? free_ext : rem_q;

  always_comb begin
    st_d       = st_q;
    rem_d      = rem_q;
    frag_d     = frag_q;
    iss        = 1'b0;
    iss_we     = 1'b0;
    iss_addr   = txdp_i;
    iss_len    = DESC_LEN;
    iss_wdata  = '0;
    iss_be     = 4'hF;
    push_h     = 1'b0;
    irq_d      = 1'b0;
    ld_o       = 1'b0;
    set_done_o = 1'b0;
    clr_txe_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (txe_i) begin
          iss = 1'b1;
          if (done_flag_i) begin
            iss_len = WORD_LEN;
            st_d    = ST_DREFR;
          end else begin
            st_d    = ST_DREAD;
          end
        end
      end
      ST_DREFR: if (done_i) st_d = ST_ADV;
      ST_DREAD: begin
        if (done_i) begin
          if (cmdsts_i[OWN_BIT]) begin
            st_d   = ST_FBLOCK;
            rem_d  = cmdsts_i[CNT_W-1:0];
            frag_d = bufptr_i;
          end else begin
            st_d   = ST_IDLE;
            irq_d  = 1'b1;
          end
        end
      end
      ST_FBLOCK: begin
        if (rem_q == '0) begin
          if (cmdsts_i[MORE_BIT]) begin
            iss       = 1'b1;
            iss_we    = 1'b1;
            iss_addr  = txdp_i + AW'(4);
            iss_len   = WORD_LEN;
            iss_wdata = {1'b0, cmdsts_i[30:0]};
            iss_be    = 4'b1100;
            st_d      = ST_DWRITE;
          end else begin
            push_h = 1'b1;
            st_d   = ST_ADV;
          end
        end else if (free_i > thr_i) begin
          iss      = 1'b1;
          iss_addr = frag_q;
          iss_len  = xfer_len;
          rem_d    = rem_q - xfer_len;
          frag_d   = frag_q + AW'(xfer_len);
          st_d     = ST_FREAD;
        end
      end
      ST_FREAD:  if (done_i) st_d = ST_FBLOCK;
      ST_DWRITE: if (done_i) st_d = ST_ADV;
      ST_ADV: begin
        if (link_i != '0) begin
          ld_o     = 1'b1;
          iss      = 1'b1;
          iss_addr = link_i;
          st_d     = ST_DREAD;
        end else begin
          set_done_o = 1'b1;
          clr_txe_o  = 1'b1;
          irq_d      = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign start_o  = iss && !iss_we;
  assign cap_en_o = rvalid_i && (st_q == ST_DREAD || st_q == ST_DREFR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      frag_q  <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      irq_q   <= 1'b0;
      fwe_q   <= 1'b0;
      ftag_q  <= 1'b0;
      fdata_q <= '0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      frag_q <= frag_d;
      irq_q  <= irq_d;
      if (iss) begin
        req_q   <= 1'b1;
        we_q    <= iss_we;
        addr_q  <= iss_addr;
        len_q   <= iss_len;
        wdata_q <= iss_wdata;
        be_q    <= iss_be;
      end else if (done_i) begin
        req_q   <= 1'b0;
      end
      fwe_q   <= push_h || (st_q == ST_FREAD && rvalid_i);
      ftag_q  <= push_h;
      fdata_q <= push_h ? 32'(txdp_i) : rdata_i;
    end
  end

  assign req_o        = req_q;
  assign we_o         = we_q;
  assign addr_o       = addr_q;
  assign len_o        = len_q;
  assign wdata_o      = wdata_q;
  assign be_o         = be_q;
  assign irq_o        = irq_q;
  assign fifo_we_o    = fwe_q;
  assign fifo_tag_o   = ftag_q;
  assign fifo_wdata_o = fdata_q;

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !done_i) |=> req_q && $stable(addr_q) && $stable(len_q) && $stable(we_q));

  // R4
  frag_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FREAD && $past(st_q) == ST_FBLOCK) |->
      (len_q != '0) && (len_q <= $past(free_ext)) && ($past(free_i) > $past(thr_i)));

  // R6
  wb_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && we_q) |-> !wdata_q[OWN_BIT] && (be_q == 4'b1100));

  // R3
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (st_q == ST_IDLE) && !$past(irq_q));
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txdesc_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned FIFO_BYTES = 64,
  localparam int unsigned FW        = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txdp_wr_i,
  input  logic [AW-1:0]    txdp_wdata_i,
  input  logic             txe_set_i,
  output logic [AW-1:0]    txdp_o,
  output logic             txe_o,
  output logic             idle_irq_o,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [CNT_W-1:0] bus_len_o,
  output logic [31:0]      bus_wdata_o,
  output logic [3:0]       bus_be_o,
  input  logic             bus_rvalid_i,
  input  logic [31:0]      bus_rdata_i,
  input  logic             bus_done_i,
  input  logic [FW-1:0]    fifo_free_i,
  input  logic [FW-1:0]    fifo_thr_i,
  output logic             fifo_we_o,
  output logic             fifo_tag_o,
  output logic [31:0]      fifo_wdata_o
);
  logic          done_flag, txe, start, cap_en, ld, set_done, clr_txe;
  logic [AW-1:0] txdp;
  logic [31:0]   link_w, cmdsts_w, bufptr_w;

  txdesc_ptr #(.AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_wr_i    (txdp_wr_i),
    .sw_wdata_i (txdp_wdata_i),
    .txe_set_i  (txe_set_i),
    .ld_i       (ld),
    .ld_addr_i  (link_w[AW-1:0]),
    .set_done_i (set_done),
    .clr_txe_i  (clr_txe),
    .txdp_o     (txdp),
    .done_o     (done_flag),
    .txe_o      (txe)
  );

  txdesc_cache u_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cap_en_i (cap_en),
    .rdata_i  (bus_rdata_i),
    .link_o   (link_w),
    .cmdsts_o (cmdsts_w),
    .bufptr_o (bufptr_w)
  );

  txdesc_fsm #(.AW(AW), .FW(FW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .txe_i        (txe),
    .done_flag_i  (done_flag),
    .txdp_i       (txdp),
    .link_i       (link_w[AW-1:0]),
    .cmdsts_i     (cmdsts_w),
    .bufptr_i     (bufptr_w[AW-1:0]),
    .free_i       (fifo_free_i),
    .thr_i        (fifo_thr_i),
    .done_i       (bus_done_i),
    .rvalid_i     (bus_rvalid_i),
    .rdata_i      (bus_rdata_i),
    .req_o        (bus_req_o),
    .we_o         (bus_we_o),
    .addr_o       (bus_addr_o),
    .len_o        (bus_len_o),
    .wdata_o      (bus_wdata_o),
    .be_o         (bus_be_o),
    .start_o      (start),
    .cap_en_o     (cap_en),
    .ld_o         (ld),
    .set_done_o   (set_done),
    .clr_txe_o    (clr_txe),
    .irq_o        (idle_irq_o),
    .fifo_we_o    (fifo_we_o),
    .fifo_tag_o   (fifo_tag_o),
    .fifo_wdata_o (fifo_wdata_o)
  );

  assign txdp_o = txdp;
  assign txe_o  = txe;

  // R9
  null_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_irq_o && !txe_o && !$past(txe_set_i)) |-> !bus_req_o);
endmodule

// File: tb/txdesc_dma_test.sv
module txdesc_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txdp_wr = 1'b0;
  logic [31:0] txdp_wdata = '0;
  logic        txe_set = 1'b0;
  logic [31:0] txdp;
  logic        txe, irq;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [11:0] bus_len;
  logic [3:0]  bus_be;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_done = 1'b0;
  logic [6:0]  fifo_free = 7'd64;
  logic [6:0]  fifo_thr = 7'd8;
  logic        fifo_we, fifo_tag;
  logic [31:0] fifo_wdata;

  always #4 clk = ~clk;

  txdesc_dma uut (
    .clk_i(clk), .rst_ni(rst_n),
    .txdp_wr_i(txdp_wr), .txdp_wdata_i(txdp_wdata), .txe_set_i(txe_set),
    .txdp_o(txdp), .txe_o(txe), .idle_irq_o(irq),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_len_o(bus_len), .bus_wdata_o(bus_wdata), .bus_be_o(bus_be),
    .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_done_i(bus_done),
    .fifo_free_i(fifo_free), .fifo_thr_i(fifo_thr),
    .fifo_we_o(fifo_we), .fifo_tag_o(fifo_tag), .fifo_wdata_o(fifo_wdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [256];
  logic [31:0] lg_addr [64];
  logic [11:0] lg_len  [64];
  logic        lg_we   [64];
  int          n_lg = 0;
  logic [31:0] fq_data [64];
  logic        fq_tag  [64];
  int          n_fq = 0;
  int          n_irq = 0;
  int          req_drop = 0;

  // memory model
  logic        busy = 1'b0, cool = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [11:0] m_len = '0;
  logic [3:0]  m_be = '0;
  int          dly = 0, beat = 0, nb = 0;

  always @(negedge clk) begin
    bus_rvalid = 1'b0;
    bus_done   = 1'b0;
    if (!rst_n) begin
      busy = 1'b0; cool = 1'b0;
    end else if (!busy) begin
      if (bus_req && !cool) begin
        m_we = bus_we; m_addr = bus_addr; m_len = bus_len;
        m_wdata = bus_wdata; m_be = bus_be;
        if (n_lg < 64) begin
          lg_addr[n_lg] = bus_addr; lg_len[n_lg] = bus_len; lg_we[n_lg] = bus_we;
          n_lg++;
        end
        busy = 1'b1; dly = 2; beat = 0;
        nb = bus_we ? 0 : (int'(bus_len) + 3) / 4;
      end
      cool = 1'b0;
    end else begin
      if (!bus_req || bus_addr != m_addr || bus_len != m_len || bus_we != m_we ||
          bus_wdata != m_wdata || bus_be != m_be)
        req_drop++;
      if (dly > 0) dly--;
      else if (beat < nb) begin
        bus_rvalid = 1'b1;
        bus_rdata  = mem[((m_addr >> 2) + beat) & 255];
        beat++;
      end else begin
        bus_done = 1'b1;
        if (m_we)
          for (int b = 0; b < 4; b++)
            if (m_be[b]) mem[(m_addr >> 2) & 255][b*8 +: 8] = m_wdata[b*8 +: 8];
        busy = 1'b0; cool = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_we && n_fq < 64) begin
        fq_data[n_fq] = fifo_wdata; fq_tag[n_fq] = fifo_tag; n_fq++;
      end
      if (irq) n_irq++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_logs();
    n_lg = 0; n_fq = 0; n_irq = 0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] lnk, input logic [31:0] cs,
                          input logic [31:0] bp);
    mem[(a >> 2) & 255]       = lnk;
    mem[((a >> 2) + 1) & 255] = cs;
    mem[((a >> 2) + 2) & 255] = bp;
  endtask

  task automatic wr_txdp(input logic [31:0] v);
    @(negedge clk); txdp_wr = 1'b1; txdp_wdata = v;
    @(negedge clk); txdp_wr = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); txe_set = 1'b1;
    @(negedge clk); txe_set = 1'b0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 2000 && txe; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_frag(input string tag, input int first, input int bp, input int nwords);
    for (int k = 0; k < nwords; k++) begin
      chk({tag, " data"}, fq_data[first+k], mem[((bp >> 2) + k) & 255]);
      chk({tag, " tag0"}, 32'(fq_tag[first+k]), 32'd0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 txdp", txdp, 32'h0);
    chk("R1 txe", 32'(txe), 32'd0);
    chk("R1 req", 32'(bus_req), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 fifo_we", 32'(fifo_we), 32'd0);
    chk("R1 req idle", 32'(bus_req), 32'd0);
  endtask

  task automatic t_single();
    clr_logs();
    fifo_free = 7'd64; fifo_thr = 7'd8;
    put_desc(32'h100, 32'h0, 32'h8000_0010, 32'h200);
    wr_txdp(32'h100);
    chk("R10 txdp visible", txdp, 32'h100);
    go();
    wait_stop();
    chk("R2 desc addr", lg_addr[0], 32'h100);
    chk("R2 desc len", 32'(lg_len[0]), 32'd12);
    chk("R4 frag addr", lg_addr[1], 32'h200);
    chk("R4 frag len", 32'(lg_len[1]), 32'd16);
    chk("R5 fifo count", 32'(n_fq), 32'd5);
    chk_frag("R5 single", 0, 32'h200, 4);
    chk("R7 handle tag", 32'(fq_tag[4]), 32'd1);
    chk("R7 handle data", fq_data[4], 32'h100);
    chk("R9 irq once", 32'(n_irq), 32'd1);
    chk("R9 txe cleared", 32'(txe), 32'd0);
  endtask

  task automatic t_split();
    clr_logs();
    fifo_free = 7'd12; fifo_thr = 7'd8;
    put_desc(32'h140, 32'h0, 32'h8000_0014, 32'h240);
    wr_txdp(32'h140);
    go();
    wait_stop();
    chk("R2 split desc", lg_addr[0], 32'h140);
    chk("R4 split len0", 32'(lg_len[0+1]), 32'd12);
    chk("R4 split addr0", lg_addr[1], 32'h240);
    chk("R4 split len1", 32'(lg_len[2]), 32'd8);
    chk("R4 split addr1", lg_addr[2], 32'h24C);
    chk("R5 split count", 32'(n_fq), 32'd6);
    chk_frag("R5 split", 0, 32'h240, 5);
    chk("R7 split handle", fq_data[5], 32'h140);
  endtask

  task automatic t_threshold();
    clr_logs();
    fifo_free = 7'd8; fifo_thr = 7'd8;
    put_desc(32'h180, 32'h0, 32'h8000_0008, 32'h280);
    wr_txdp(32'h180);
    go();
    repeat (40) @(negedge clk);
    chk("R4 blocked reqs", 32'(n_lg), 32'd1);
    chk("R4 blocked fifo", 32'(n_fq), 32'd0);
    chk("R4 blocked txe", 32'(txe), 32'd1);
    fifo_free = 7'd9;
    wait_stop();
    chk("R4 unblocked len", 32'(lg_len[1]), 32'd8);
    chk("R5 unblocked count", 32'(n_fq), 32'd3);
  endtask

  task automatic t_chain();
    clr_logs();
    fifo_free = 7'd64; fifo_thr = 7'd8;
    put_desc(32'h1C0, 32'h1E0, 32'hC800_0008, 32'h300);
    put_desc(32'h1E0, 32'h0,   32'h8000_0004, 32'h320);
    wr_txdp(32'h1C0);
    go();
    wait_stop();
    chk("R6 wb addr", lg_addr[2], 32'h1C4);
    chk("R6 wb is write", 32'(lg_we[2]), 32'd1);
    chk("R6 wb memory", mem[(32'h1C4 >> 2)], 32'h4800_0008);
    chk("R8 next desc addr", lg_addr[3], 32'h1E0);
    chk("R8 next desc len", 32'(lg_len[3]), 32'd12);
    chk("R8 txdp link", txdp, 32'h1E0);
    chk("R6 no mid handle", 32'(fq_tag[2]), 32'd0);
    chk("R7 last handle", fq_data[3], 32'h1E0);
    chk("R7 last tag", 32'(fq_tag[3]), 32'd1);
    chk("R6 last not written", mem[(32'h1E4 >> 2)], 32'h8000_0004);
  endtask

  task automatic t_refresh();
    clr_logs();
    put_desc(32'h220, 32'h0, 32'h8000_0004, 32'h340);
    mem[32'h1E0 >> 2] = 32'h220;
    go();
    wait_stop();
    chk("R9 refresh addr", lg_addr[0], 32'h1E0);
    chk("R9 refresh len", 32'(lg_len[0]), 32'd4);
    chk("R8 follow addr", lg_addr[1], 32'h220);
    chk("R8 txdp follow", txdp, 32'h220);
    chk("R5 refresh count", 32'(n_fq), 32'd2);
    chk_frag("R5 refresh", 0, 32'h340, 1);
    chk("R7 refresh handle", fq_data[1], 32'h220);
  endtask

  task automatic t_not_owned();
    clr_logs();
    put_desc(32'h260, 32'h0, 32'h0000_0004, 32'h360);
    wr_txdp(32'h260);
    go();
    for (int i = 0; i < 500 && n_irq < 2; i++) @(negedge clk);
    chk("R3 irq repeats", 32'(n_irq >= 2), 32'd1);
    chk("R3 no data", 32'(n_fq), 32'd0);
    chk("R3 txe kept", 32'(txe), 32'd1);
    chk("R3 refetch addr", lg_addr[1], 32'h260);
    mem[(32'h264 >> 2)] = 32'h8000_0004;
    wait_stop();
    chk("R3 proceeds count", 32'(n_fq), 32'd2);
    chk("R3 proceeds handle", fq_data[1], 32'h260);
  endtask

  task automatic t_txdp_write();
    clr_logs();
    wr_txdp(32'h100);
    chk("R10 txdp new", txdp, 32'h100);
    go();
    wait_stop();
    chk("R10 full read addr", lg_addr[0], 32'h100);
    chk("R10 full read len", 32'(lg_len[0]), 32'd12);
    chk("R11 req held", 32'(req_drop), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | 32'(i);
    t_reset();
    t_single();
    t_split();
    t_threshold();
    t_chain();
    t_refresh();
    t_not_owned();
    t_txdp_write();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule